// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire serial audio stream (bit clock, frame sync and serial data) into parallel samples, one per channel slot. All three wires are sampled by the system clock. A rising bit clock edge is found by comparing two registered copies of the bit clock, and frame sync and data are taken at that edge. Software picks one of three framings and one of four word widths. Every completed word is sign-extended to 24 bits and presented with a left/right flag and a valid pulse that lasts one system clock cycle.

The block follows frame sync transitions to find each word. In left-justified framing the MSB is in the first bit after a transition. In I2S framing the MSB comes one bit later. In right-justified framing the word is closed by the next transition, so its LSB is the last bit before that transition. A channel slot that ends before a full word has arrived raises an error pulse in place of a sample.

Top module: `audio_rx`

## Requirements
- R1: With `fmtSel` = 0 (left-justified), the bit sampled at the first rising bit clock edge after a frame sync transition is the MSB of the word. The following width-1 bits complete the word down to its LSB.
- R2: With `fmtSel` = 1 (I2S), the MSB is the bit one bit clock after the frame sync transition. Frame sync low carries the left channel.
- R3: With `fmtSel` = 2 (right-justified), the word is the last N bits sampled before the next frame sync transition, where N is the selected width. This holds even when the slot is exactly N bits long.
- R4: `widthSel` selects the word width: 0 selects 16 bits, 1 selects 18, 2 selects 20 and 3 selects 24.
- R5: `sampleOut` carries the received word in bits N-1..0. Every bit above N-1 is a copy of bit N-1.
- R6: `chanRight` is 0 for a left sample and 1 for a right sample. In left-justified and right-justified framing, frame sync high marks the left channel.
- R7: Each complete channel slot produces exactly one `sampleValid` pulse, one system clock cycle long.
- R8: A slot with too few bits for the selected framing and width raises `frameErr` for one cycle, with `chanRight` naming that slot, and produces no `sampleValid`. Right-justified framing needs at least N bits; the other two framings need the bits up to and including the LSB.
- R9: During reset and after it, all outputs are 0. Nothing is emitted until the block has seen a frame sync transition.
- R10: Frame sync and data are taken only at rising bit clock edges. Changes of `sdIn` while the bit clock is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the serial wires |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial bit clock |
| fsIn | input | 1 | Frame sync (channel select) |
| sdIn | input | 1 | Serial data, MSB first |
| fmtSel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified |
| widthSel | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| sampleOut | output | 24 | Sign-extended received word |
| chanRight | output | 1 | 1 = right channel, 0 = left |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| frameErr | output | 1 | One-cycle strobe for a short slot |

## Verification
The assertions depend on three conditions. Each bit clock phase must last at least two system clock cycles, so that rising edges stay at least two cycles apart. Frame sync and data must change only while the bit clock is low. `fmtSel` and `widthSel` must not change while a stream is running. The bench generates the bit clock with four system clocks per phase and drives frame sync and data right after the falling edge. It resets the block before every change of framing or width. In one run it deliberately toggles data during the high phase, to show that those changes are ignored.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  localparam int SAMPLE_W = 24;

  typedef struct packed {
    logic shiftEn;    // rising bit clock edge: shift in one bit
    logic bitIn;      // data bit taken at that edge
    logic latchNew;   // word ends with the bit taken now
    logic latchOld;   // word ended with the previous bit
    logic chanRight;  // channel of the word or error
    logic flagErr;    // slot ended before a full word
  } strobe_t;

  function automatic int unsigned widthOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] signExtend(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [1:0] sel);
    logic [SAMPLE_W-1:0] res;
    int n;
    n = int'(widthOf(sel));
    for (int i = 0; i < SAMPLE_W; i++) begin
      res[i] = (i < n) ? raw[i] : raw[n-1];
    end
    return res;
  endfunction

endpackage

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       fsIn,
  input  logic       sdIn,
  input  logic [1:0] fmtSel,
  input  logic [1:0] widthSel,
  output strobe_t    strobe
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic sclkQ, sclkPrev, fsQ, sdQ;
  logic fsLast, fsSeen, armed, done;
  logic [CNT_W-1:0] bitIdx, nextIdx, wordLen, msbTarget;
  logic [CNT_W:0]   halfLen;
  logic rise, isEdge, fmtI2s, fmtRj, chanNow, chanPrev;

  // input sampler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      sclkPrev <= 1'b0;
      fsQ      <= 1'b0;
      sdQ      <= 1'b0;
    end else begin
      sclkQ    <= sclkIn;
      sclkPrev <= sclkQ;
      fsQ      <= fsIn;
      sdQ      <= sdIn;
    end
  end

  assign rise      = sclkQ & ~sclkPrev;
  assign isEdge    = fsSeen && (fsQ != fsLast);
  assign fmtI2s    = (fmtSel == 2'd1);
  assign fmtRj     = (fmtSel == 2'd2);
  assign chanNow   = fmtI2s ? fsQ : ~fsQ;
  assign chanPrev  = fmtI2s ? fsLast : ~fsLast;
  assign wordLen   = CNT_W'(widthOf(widthSel));
  assign msbTarget = fmtI2s ? wordLen : wordLen - 1'b1;
  assign halfLen   = {1'b0, bitIdx} + 1'b1;
  assign nextIdx   = isEdge ? '0 : ((bitIdx == CNT_MAX) ? bitIdx : bitIdx + 1'b1);

  always_comb begin
    strobe           = '0;
    strobe.shiftEn   = rise;
    strobe.bitIn     = sdQ;
    if (rise && armed) begin
      if (fmtRj) begin
        if (isEdge) begin
          strobe.chanRight = chanPrev;
          if (halfLen >= {1'b0, wordLen}) strobe.latchOld = 1'b1;
          else                            strobe.flagErr  = 1'b1;
        end
      end else begin
        if (isEdge && !done) begin
          strobe.flagErr   = 1'b1;
          strobe.chanRight = chanPrev;
        end else if (!isEdge && !done && nextIdx == msbTarget) begin
          strobe.latchNew  = 1'b1;
          strobe.chanRight = chanNow;
        end
      end
    end
  end

  // slot tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsLast <= 1'b0;
      fsSeen <= 1'b0;
      armed  <= 1'b0;
      done   <= 1'b0;
      bitIdx <= '0;
    end else if (rise) begin
      fsSeen <= 1'b1;
      fsLast <= fsQ;
      bitIdx <= nextIdx;
      if (isEdge) begin
        armed <= 1'b1;
        done  <= 1'b0;
      end else if (strobe.latchNew) begin
        done  <= 1'b1;
      end
    end
  end

  // R10
  latch_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchNew || strobe.latchOld || strobe.flagErr) |-> rise);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagErr |-> !(strobe.latchNew || strobe.latchOld));

  // R9
  armed_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchNew || strobe.latchOld) |-> fsSeen);

endmodule

// File: rtl/audio_rx_path.sv
module audio_rx_path
  import audio_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [1:0]          widthSel,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                chanRight,
  output logic                sampleValid,
  output logic                frameErr
);

  logic [SAMPLE_W-1:0] shiftReg, withNew, rawWord;

  assign withNew = {shiftReg[SAMPLE_W-2:0], strobe.bitIn};
  assign rawWord = strobe.latchNew ? withNew : shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sampleOut   <= '0;
      chanRight   <= 1'b0;
      sampleValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= withNew;
      sampleValid <= strobe.latchNew | strobe.latchOld;
      frameErr    <= strobe.flagErr;
      if (strobe.latchNew || strobe.latchOld) begin
        sampleOut <= signExtend(rawWord, widthSel);
        chanRight <= strobe.chanRight;
      end else if (strobe.flagErr) begin
        chanRight <= strobe.chanRight;
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8
  valid_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && frameErr));

  // R5
  sext16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && widthSel == 2'd0) |->
      ($countones(sampleOut[SAMPLE_W-1:15]) == 0 || $countones(sampleOut[SAMPLE_W-1:15]) == 9));

endmodule

// File: rtl/audio_rx.sv
module audio_rx
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclkIn,
  input  logic                fsIn,
  input  logic                sdIn,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          widthSel,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                chanRight,
  output logic                sampleValid,
  output logic                frameErr
);

  strobe_t strobe;

  audio_rx_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .fsIn(fsIn), .sdIn(sdIn),
    .fmtSel(fmtSel), .widthSel(widthSel), .strobe(strobe)
  );

  audio_rx_path path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .widthSel(widthSel),
    .sampleOut(sampleOut), .chanRight(chanRight),
    .sampleValid(sampleValid), .frameErr(frameErr)
  );

endmodule

// File: tb/audio_rx_test.sv
`timescale 1ns/1ps
module audio_rx_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, fsIn = 1'b0, sdIn = 1'b0;
  logic [1:0] fmtSel = 2'd0, widthSel = 2'd0;
  logic [23:0] sampleOut;
  logic chanRight, sampleValid, frameErr;

  always #2.5 clk = ~clk;

  audio_rx uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .fsIn(fsIn), .sdIn(sdIn),
    .fmtSel(fmtSel), .widthSel(widthSel), .sampleOut(sampleOut),
    .chanRight(chanRight), .sampleValid(sampleValid), .frameErr(frameErr)
  );

  int checks = 0, fails = 0;
  int gotN = 0, errN = 0, dblN = 0;
  logic [23:0] gotVal [8];
  logic gotCh [8];
  logic lastErrCh = 1'b0, prevValid = 1'b0;
  bit glitchOn = 1'b0;
  bit finished = 1'b0;

  // fmt, width, left, right
  localparam logic [51:0] VEC [12] = '{
    {2'd0, 2'd0, 24'hA5C3E1, 24'h1B2D4F},
    {2'd0, 2'd1, 24'h03F00D, 24'h02ABCD},
    {2'd0, 2'd2, 24'h08C001, 24'h07FFFF},
    {2'd0, 2'd3, 24'h800001, 24'h7FFFFE},
    {2'd1, 2'd0, 24'h007FFF, 24'h008000},
    {2'd1, 2'd1, 24'h020001, 24'h01FFFE},
    {2'd1, 2'd2, 24'h0F1234, 24'h05A5A5},
    {2'd1, 2'd3, 24'hC0FFEE, 24'h123456},
    {2'd2, 2'd0, 24'h00F0F0, 24'h000F0F},
    {2'd2, 2'd1, 24'h035555, 24'h00AAAA},
    {2'd2, 2'd2, 24'h0ABCDE, 24'h013579},
    {2'd2, 2'd3, 24'hFEDCBA, 24'h2468AC}
  };

  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        if (gotN < 8) begin
          gotVal[gotN] = sampleOut;
          gotCh[gotN]  = chanRight;
        end
        gotN++;
      end
      if (sampleValid && prevValid) dblN++;
      if (frameErr) begin
        errN++;
        lastErrCh = chanRight;
      end
      prevValid = sampleValid;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int widthN(input logic [1:0] sel);
    case (sel)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] v, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  task automatic slot(input logic lvl, input logic b);
    @(negedge clk);
    sclkIn = 1'b0;
    fsIn = lvl;
    sdIn = b;
    repeat (4) @(negedge clk);
    sclkIn = 1'b1;
    @(negedge clk);
    if (glitchOn) sdIn = ~b;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendHalf(input logic lvl, input int len, input logic [1:0] fmt,
                          input int n, input logic [23:0] val);
    for (int k = 0; k < len; k++) begin
      logic b;
      b = 1'b0;
      if (fmt == 2'd1) begin
        if (k >= 1 && k <= n) b = val[n-k];
      end else if (fmt == 2'd2) begin
        if (k >= len - n) b = val[len-1-k];
      end else begin
        if (k < n) b = val[n-1-k];
      end
      slot(lvl, b);
    end
  endtask

  task automatic doReset(input logic [1:0] fmt, input logic [1:0] wsel);
    @(negedge clk);
    rstN = 1'b0;
    sclkIn = 1'b0;
    fsIn = 1'b0;
    sdIn = 1'b0;
    fmtSel = fmt;
    widthSel = wsel;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    gotN = 0;
    errN = 0;
    dblN = 0;
    prevValid = 1'b0;
  endtask

  task automatic runStream(input logic [1:0] fmt, input logic [1:0] wsel,
                           input logic [23:0] l, input logic [23:0] r, input int len);
    logic leftLvl;
    int n;
    n = widthN(wsel);
    leftLvl = (fmt == 2'd1) ? 1'b0 : 1'b1;
    doReset(fmt, wsel);
    sendHalf(~leftLvl, 4, fmt, n, 24'd0);
    sendHalf(leftLvl, len, fmt, n, l);
    sendHalf(~leftLvl, len, fmt, n, r);
    sendHalf(leftLvl, 4, fmt, n, 24'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic checkPair(input string tag, input logic [1:0] wsel,
                           input logic [23:0] l, input logic [23:0] r);
    int n;
    logic [23:0] el, er;
    n = widthN(wsel);
    el = sext(l, n);
    er = sext(r, n);
    check(gotN == 2, {tag, " R7 sample count"}, gotN, 2);
    check(errN == 0, {tag, " R8 no error"}, errN, 0);
    check(dblN == 0, {tag, " R7 single-cycle valid"}, dblN, 0);
    if (gotN == 2) begin
      check(gotVal[0] == el, {tag, " R4 R5 left word"}, gotVal[0], el);
      check(gotVal[1] == er, {tag, " R4 R5 right word"}, gotVal[1], er);
      check(gotCh[0] == 1'b0 && gotCh[1] == 1'b1, {tag, " R6 channel flags"},
            {gotCh[0], gotCh[1]}, 2'b01);
    end
  endtask

  initial begin
    // R9 reset state
    doReset(2'd0, 2'd0);
    @(negedge clk);
    check(sampleOut == 0 && !chanRight && !sampleValid && !frameErr, "R9 reset outputs",
          {sampleOut, chanRight, sampleValid, frameErr}, 0);

    // table of formats and widths (R1 left-justified, R2 I2S, R3 right-justified)
    for (int v = 0; v < 12; v++) begin
      logic [1:0] f, w;
      string tag;
      {f, w} = VEC[v][51:48];
      tag = (f == 2'd0) ? "R1" : (f == 2'd1) ? "R2" : "R3";
      runStream(f, w, VEC[v][47:24], VEC[v][23:0], 32);
      checkPair(tag, w, VEC[v][47:24], VEC[v][23:0]);
    end

    // R9 no frame sync transition: nothing emitted
    doReset(2'd0, 2'd0);
    sendHalf(1'b1, 40, 2'd0, 16, 24'h00FFFF);
    repeat (8) @(negedge clk);
    check(gotN == 0 && errN == 0, "R9 no output before transition", {gotN[15:0], errN[15:0]}, 0);

    // R8 short slots, left-justified width 24 with 16-bit slots
    runStream(2'd0, 2'd3, 24'h123456, 24'h654321, 16);
    check(errN == 2, "R8 short slot errors LJ", errN, 2);
    check(gotN == 0, "R8 no valid on short LJ", gotN, 0);
    check(lastErrCh == 1'b1, "R8 error channel", lastErrCh, 1'b1);

    // R8 short slots, right-justified
    runStream(2'd2, 2'd3, 24'h123456, 24'h654321, 16);
    check(errN == 2 && gotN == 0, "R8 short slot errors RJ", {errN[15:0], gotN[15:0]}, 32'h00020000);

    // R8 I2S needs one extra bit: slot length equal to width is short
    runStream(2'd1, 2'd2, 24'h0ABCDE, 24'h012345, 20);
    check(errN == 2 && gotN == 0, "R8 I2S slot equal to width", {errN[15:0], gotN[15:0]}, 32'h00020000);

    // R3 right-justified slot exactly as long as the word
    runStream(2'd2, 2'd2, 24'h0ABCDE, 24'h012345, 20);
    checkPair("R3 exact-length", 2'd2, 24'h0ABCDE, 24'h012345);

    // R1 left-justified slot exactly as long as the word
    runStream(2'd0, 2'd1, 24'h02AAAA, 24'h015555, 18);
    checkPair("R1 exact-length", 2'd1, 24'h02AAAA, 24'h015555);

    // R10 data toggled during the high phase is ignored
    glitchOn = 1'b1;
    runStream(2'd0, 2'd3, 24'h9ABCDE, 24'h3C3C3C, 32);
    glitchOn = 1'b0;
    checkPair("R10 glitch", 2'd3, 24'h9ABCDE, 24'h3C3C3C);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule